// File: doc/BRIEF.md
# PCIe User Interrupt Handshaker

This block connects a set of user-logic event sources to the per-line user interrupt pins of a PCIe DMA endpoint. Each line has one request output toward the endpoint and one acknowledge input back from it. A source event is a rising edge, found after the source has crossed a multi-stage synchronizer. The edge raises that line's request. The request is then retired by a handshake chosen for the interrupt mode in use: legacy INTx, MSI or MSI-X. A second event that arrives while a line is still busy is kept in a one-deep pending flag and is issued once the line is free again.

Host software drives the block through a small AXI4-Lite slave with three words. The control word holds the global enable and the mode field. The clear word is write-to-clear: a 1 in bit n retires line n's request, and the word empties itself one cycle after the write. The status word reads back the request and pending vectors.

Each line runs a four-state machine:
- `LN_IDLE`: no request.
- `LN_ASSERT`: request high, waiting for an acknowledge.
- `LN_REARM`: legacy only. Request low, waiting for the second acknowledge.
- `LN_HELD`: MSI only. Request high, already acknowledged, waiting for the software clear.

The transitions are:
- *raise*: `LN_IDLE` to `LN_ASSERT`, on a rising edge or a pending flag.
- *first-ack*: `LN_ASSERT` to `LN_REARM` (legacy), to `LN_HELD` (MSI) or to `LN_IDLE` (MSI-X and the reserved code 3).
- *second-ack*: `LN_REARM` to `LN_IDLE`.
- *sw-clear*: any state to `LN_IDLE`.
- *disable*: all state to zero.

The AXI side has two small machines. The write channel uses `WR_IDLE` to `WR_RESP` (*accept*) and back on BREADY (*respond*). The read channel uses `RD_IDLE` to `RD_DATA` and back on RREADY in the same way.

Top module: `pcie_uirq_handshaker`

## Requirements
- R1: `NUM_LINES` (1 to 16, default 16) lines operate independently. Stimulus on line n changes only bit n of `irq_req_o`.
- R2: Each source crosses `SYNC_STAGES` (default 3) flops. Only a 0-to-1 transition raises a request, and it shows on `irq_req_o` after the fourth rising clock edge that follows the source change. A source held high does not raise a new request.
- R3: In legacy mode (mode code 0), the first acknowledge drops the request. The request stays low until a second acknowledge, and only after that can the line request again.
- R4: In MSI mode (mode code 1), an acknowledge leaves the request high. The request stays high until software clears the line.
- R5: In MSI-X mode (mode code 2), an acknowledge drops the request in the next cycle.
- R6: Bit 31 of the control word (byte offset 0x4) is the global enable. Writing 0xFFFF0000 starts legacy operation and writing 0 stops it. A read returns `{enable, 29'b0, mode}`.
- R7: Writing 1 to bit n of the clear word (offset 0x0) returns line n to idle, so its request is low. The word empties itself one cycle later, so a later event on that line raises a request that stays up.
- R8: While the enable is 0, all synchronizer, pending and request state is zero and source edges are ignored. Clearing the enable drops every request and pending flag.
- R9: The mode sits in bits 1:0 of the control word and is taken only from a write made while the block is disabled. A write made while enabled leaves the mode unchanged, and the readback shows this.
- R10: An edge that arrives while a line is not idle sets that line's one-deep pending flag. Once the line returns to idle, the flag raises a new request one cycle later and is cleared.
- R11: The status word (offset 0x8) returns the requests in bits 15:0 and the pending flags in bits 31:16. Every write and read response is OKAY (2'b00).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for all logic |
| rst_n | input | 1 | Synchronous reset, active low |
| src_i | input | NUM_LINES | Asynchronous event sources, one per line |
| irq_ack_i | input | NUM_LINES | Acknowledge pulses from the endpoint |
| irq_req_o | output | NUM_LINES | Interrupt requests to the endpoint |
| s_awaddr | input | ADDR_W | Write address |
| s_awvalid | input | 1 | Write address valid |
| s_awready | output | 1 | Write address ready |
| s_wdata | input | 32 | Write data |
| s_wvalid | input | 1 | Write data valid |
| s_wready | output | 1 | Write data ready |
| s_bresp | output | 2 | Write response |
| s_bvalid | output | 1 | Write response valid |
| s_bready | input | 1 | Write response ready |
| s_araddr | input | ADDR_W | Read address |
| s_arvalid | input | 1 | Read address valid |
| s_arready | output | 1 | Read address ready |
| s_rdata | output | 32 | Read data |
| s_rresp | output | 2 | Read response |
| s_rvalid | output | 1 | Read data valid |
| s_rready | input | 1 | Read data ready |

## Verification
A line machine left in the wrong state shows up on `irq_req_o` within one or two cycles of the next acknowledge or clear. A legacy line stuck in `LN_REARM` never raises again. An MSI line that skips `LN_HELD` drops on the acknowledge instead of on the clear. A lost or spurious pending flag is seen in bits 31:16 of the status word at the next read. It is also seen as a request that does or does not come back one cycle after the line returns to idle. The bench covers every line in every mode, so a fault confined to one line or one mode still reaches the ports.

// File: rtl/uirq_hs_pkg.sv
package uirq_hs_pkg;

    // Interrupt retire mode, as held in bits 1:0 of the control word.
    typedef enum logic [1:0] {
        MODE_LEGACY = 2'd0,
        MODE_MSI    = 2'd1,
        MODE_MSIX   = 2'd2,
        MODE_RSVD   = 2'd3
    } irq_mode_e;

    // Per-line handshake state.
    typedef enum logic [1:0] {
        LN_IDLE,
        LN_ASSERT,
        LN_REARM,
        LN_HELD
    } line_state_e;

    typedef enum logic {
        WR_IDLE,
        WR_RESP
    } wr_state_e;

    typedef enum logic {
        RD_IDLE,
        RD_DATA
    } rd_state_e;

    // Byte offsets of the three register words.
    localparam int OFS_CLEAR  = 'h0;
    localparam int OFS_CTRL   = 'h4;
    localparam int OFS_STATUS = 'h8;

    localparam int CTRL_EN_BIT   = 31;
    localparam int STATUS_PEND_LSB = 16;
    localparam int DATA_W        = 32;

endpackage

// File: rtl/uirq_hs_csr.sv
module uirq_hs_csr
    import uirq_hs_pkg::*;
#(
    parameter int NUM_LINES = 16,
    parameter int ADDR_W    = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [ADDR_W-1:0]    s_awaddr,
    input  logic                 s_awvalid,
    output logic                 s_awready,
    input  logic [DATA_W-1:0]    s_wdata,
    input  logic                 s_wvalid,
    output logic                 s_wready,
    output logic [1:0]           s_bresp,
    output logic                 s_bvalid,
    input  logic                 s_bready,
    input  logic [ADDR_W-1:0]    s_araddr,
    input  logic                 s_arvalid,
    output logic                 s_arready,
    output logic [DATA_W-1:0]    s_rdata,
    output logic [1:0]           s_rresp,
    output logic                 s_rvalid,
    input  logic                 s_rready,
    input  logic [NUM_LINES-1:0] req_i,
    input  logic [NUM_LINES-1:0] pend_i,
    output logic                 en_o,
    output irq_mode_e            mode_o,
    output logic [NUM_LINES-1:0] clr_o
);

    localparam logic [ADDR_W-1:0] A_CLEAR  = ADDR_W'(OFS_CLEAR);
    localparam logic [ADDR_W-1:0] A_CTRL   = ADDR_W'(OFS_CTRL);
    localparam logic [ADDR_W-1:0] A_STATUS = ADDR_W'(OFS_STATUS);

    wr_state_e wr_state_q, wr_state_d;
    rd_state_e rd_state_q, rd_state_d;

    logic                 en_q;
    irq_mode_e            mode_q;
    logic [NUM_LINES-1:0] clr_q;
    logic [DATA_W-1:0]    rdata_q;
    logic [DATA_W-1:0]    rd_word;
    logic [DATA_W-1:0]    status_word;
    logic                 wr_fire;
    logic                 rd_fire;
    logic                 unused_wdata;

    assign unused_wdata = ^s_wdata;

    // Write channel state register.
    always_ff @(posedge clk) begin
        if (!rst_n) wr_state_q <= WR_IDLE;
        else        wr_state_q <= wr_state_d;
    end

    always_comb begin
        wr_state_d = wr_state_q;
        unique case (wr_state_q)
            WR_IDLE: if (s_awvalid && s_wvalid) wr_state_d = WR_RESP;
            WR_RESP: if (s_bready)              wr_state_d = WR_IDLE;
            default:                            wr_state_d = WR_IDLE;
        endcase
    end

    // Read channel state register.
    always_ff @(posedge clk) begin
        if (!rst_n) rd_state_q <= RD_IDLE;
        else        rd_state_q <= rd_state_d;
    end

    always_comb begin
        rd_state_d = rd_state_q;
        unique case (rd_state_q)
            RD_IDLE: if (s_arvalid) rd_state_d = RD_DATA;
            RD_DATA: if (s_rready)  rd_state_d = RD_IDLE;
            default:                rd_state_d = RD_IDLE;
        endcase
    end

    // Channel outputs.
    always_comb begin
        s_awready = (wr_state_q == WR_IDLE);
        s_wready  = (wr_state_q == WR_IDLE);
        s_bvalid  = (wr_state_q == WR_RESP);
        s_bresp   = 2'b00;
        s_arready = (rd_state_q == RD_IDLE);
        s_rvalid  = (rd_state_q == RD_DATA);
        s_rresp   = 2'b00;
        s_rdata   = rdata_q;
    end

    assign wr_fire = (wr_state_q == WR_IDLE) && s_awvalid && s_wvalid;
    assign rd_fire = (rd_state_q == RD_IDLE) && s_arvalid;

    always_comb begin
        status_word = '0;
        status_word[NUM_LINES-1:0] = req_i;
        status_word[STATUS_PEND_LSB +: NUM_LINES] = pend_i;
    end

    always_comb begin
        rd_word = '0;
        if (s_araddr == A_CTRL) begin
            rd_word[CTRL_EN_BIT] = en_q;
            rd_word[1:0]         = mode_q;
        end else if (s_araddr == A_STATUS) begin
            rd_word = status_word;
        end
    end

    // Control, clear and read data registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q    <= 1'b0;
            mode_q  <= MODE_LEGACY;
            clr_q   <= '0;
            rdata_q <= '0;
        end else begin
            clr_q <= (wr_fire && s_awaddr == A_CLEAR) ? s_wdata[NUM_LINES-1:0] : '0;
            if (wr_fire && s_awaddr == A_CTRL) begin
                en_q <= s_wdata[CTRL_EN_BIT];
                if (!en_q) mode_q <= irq_mode_e'(s_wdata[1:0]);
            end
            if (rd_fire) rdata_q <= rd_word;
        end
    end

    assign en_o   = en_q;
    assign mode_o = mode_q;
    assign clr_o  = clr_q;

    // R7: the clear word holds its value for one cycle only.
    assert_clear_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (|clr_q) |=> (clr_q == '0));

    // R9: the mode does not move while the block is enabled.
    assert_mode_locked_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (en_q && $past(en_q)) |-> $stable(mode_q));

endmodule

// File: rtl/uirq_hs_sync.sv
module uirq_hs_sync #(
    parameter int NUM_LINES   = 16,
    parameter int SYNC_STAGES = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 en_i,
    input  logic [NUM_LINES-1:0] src_i,
    output logic [NUM_LINES-1:0] rise_o
);

    logic [NUM_LINES-1:0] stage_q [SYNC_STAGES];
    logic [NUM_LINES-1:0] last_q;

    always_ff @(posedge clk) begin
        if (!rst_n || !en_i) begin
            for (int s = 0; s < SYNC_STAGES; s++) stage_q[s] <= '0;
            last_q <= '0;
        end else begin
            stage_q[0] <= src_i;
            for (int s = 1; s < SYNC_STAGES; s++) stage_q[s] <= stage_q[s-1];
            last_q <= stage_q[SYNC_STAGES-1];
        end
    end

    assign rise_o = stage_q[SYNC_STAGES-1] & ~last_q;

    // R2: a rise is never reported in two consecutive cycles on one line.
    assert_single_rise_R2: assert property (@(posedge clk) disable iff (!rst_n || !en_i)
        (|rise_o) |=> ((rise_o & $past(rise_o)) == '0));

endmodule

// File: rtl/uirq_hs_line.sv
module uirq_hs_line
    import uirq_hs_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      en_i,
    input  irq_mode_e mode_i,
    input  logic      rise_i,
    input  logic      ack_i,
    input  logic      clr_i,
    output logic      req_o,
    output logic      pend_o
);

    line_state_e state_q, state_d;
    logic        pend_q, pend_d;

    // State register: all state held at zero while disabled (R8).
    always_ff @(posedge clk) begin
        if (!rst_n || !en_i) begin
            state_q <= LN_IDLE;
            pend_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            pend_q  <= pend_d;
        end
    end

    // Next state.
    always_comb begin
        state_d = state_q;
        pend_d  = pend_q;
        unique case (state_q)
            LN_IDLE: begin
                if (rise_i || pend_q) begin
                    state_d = LN_ASSERT;
                    pend_d  = 1'b0;
                end
            end
            LN_ASSERT: begin
                if (rise_i) pend_d = 1'b1;
                if (clr_i) begin
                    state_d = LN_IDLE;
                end else if (ack_i) begin
                    unique case (mode_i)
                        MODE_LEGACY: state_d = LN_REARM;
                        MODE_MSI:    state_d = LN_HELD;
                        default:     state_d = LN_IDLE;
                    endcase
                end
            end
            LN_REARM: begin
                if (rise_i) pend_d = 1'b1;
                if (clr_i || ack_i) state_d = LN_IDLE;
            end
            LN_HELD: begin
                if (rise_i) pend_d = 1'b1;
                if (clr_i) state_d = LN_IDLE;
            end
            default: state_d = LN_IDLE;
        endcase
    end

    // Outputs.
    always_comb begin
        req_o  = (state_q == LN_ASSERT) || (state_q == LN_HELD);
        pend_o = pend_q;
    end

    // R3: first legacy ack drops the request.
    assert_legacy_drop_R3: assert property (@(posedge clk) disable iff (!rst_n || !en_i)
        (mode_i == MODE_LEGACY && req_o && ack_i && !clr_i) |=> !req_o);

    // R3: while waiting for the second ack the request stays low.
    assert_legacy_gap_R3: assert property (@(posedge clk) disable iff (!rst_n || !en_i)
        (state_q == LN_REARM && !ack_i && !clr_i) |=> !req_o);

    // R4: an MSI ack leaves the request high.
    assert_msi_hold_R4: assert property (@(posedge clk) disable iff (!rst_n || !en_i)
        (mode_i == MODE_MSI && req_o && !clr_i) |=> req_o);

    // R5: an MSI-X ack drops the request.
    assert_msix_drop_R5: assert property (@(posedge clk) disable iff (!rst_n || !en_i)
        (mode_i == MODE_MSIX && req_o && ack_i) |=> !req_o);

    // R7: a software clear always leaves the request low next cycle.
    assert_sw_clear_R7: assert property (@(posedge clk) disable iff (!rst_n || !en_i)
        clr_i |=> !req_o);

    // R10: the pending flag is set only by a rising edge.
    assert_pend_from_rise_R10: assert property (@(posedge clk) disable iff (!rst_n || !en_i)
        $rose(pend_o) |-> $past(rise_i));

endmodule

// File: rtl/pcie_uirq_handshaker.sv
module pcie_uirq_handshaker
    import uirq_hs_pkg::*;
#(
    parameter int NUM_LINES   = 16,
    parameter int SYNC_STAGES = 3,
    parameter int ADDR_W      = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LINES-1:0] src_i,
    input  logic [NUM_LINES-1:0] irq_ack_i,
    output logic [NUM_LINES-1:0] irq_req_o,
    input  logic [ADDR_W-1:0]    s_awaddr,
    input  logic                 s_awvalid,
    output logic                 s_awready,
    input  logic [31:0]          s_wdata,
    input  logic                 s_wvalid,
    output logic                 s_wready,
    output logic [1:0]           s_bresp,
    output logic                 s_bvalid,
    input  logic                 s_bready,
    input  logic [ADDR_W-1:0]    s_araddr,
    input  logic                 s_arvalid,
    output logic                 s_arready,
    output logic [31:0]          s_rdata,
    output logic [1:0]           s_rresp,
    output logic                 s_rvalid,
    input  logic                 s_rready
);

    logic                 en;
    irq_mode_e            mode;
    logic [NUM_LINES-1:0] clr_vec;
    logic [NUM_LINES-1:0] rise_vec;
    logic [NUM_LINES-1:0] req_vec;
    logic [NUM_LINES-1:0] pend_vec;

    uirq_hs_csr #(
        .NUM_LINES (NUM_LINES),
        .ADDR_W    (ADDR_W)
    ) u_csr (
        .clk       (clk),
        .rst_n     (rst_n),
        .s_awaddr  (s_awaddr),
        .s_awvalid (s_awvalid),
        .s_awready (s_awready),
        .s_wdata   (s_wdata),
        .s_wvalid  (s_wvalid),
        .s_wready  (s_wready),
        .s_bresp   (s_bresp),
        .s_bvalid  (s_bvalid),
        .s_bready  (s_bready),
        .s_araddr  (s_araddr),
        .s_arvalid (s_arvalid),
        .s_arready (s_arready),
        .s_rdata   (s_rdata),
        .s_rresp   (s_rresp),
        .s_rvalid  (s_rvalid),
        .s_rready  (s_rready),
        .req_i     (req_vec),
        .pend_i    (pend_vec),
        .en_o      (en),
        .mode_o    (mode),
        .clr_o     (clr_vec)
    );

    uirq_hs_sync #(
        .NUM_LINES   (NUM_LINES),
        .SYNC_STAGES (SYNC_STAGES)
    ) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .en_i   (en),
        .src_i  (src_i),
        .rise_o (rise_vec)
    );

    for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
        uirq_hs_line u_line (
            .clk    (clk),
            .rst_n  (rst_n),
            .en_i   (en),
            .mode_i (mode),
            .rise_i (rise_vec[g]),
            .ack_i  (irq_ack_i[g]),
            .clr_i  (clr_vec[g]),
            .req_o  (req_vec[g]),
            .pend_o (pend_vec[g])
        );
    end

    assign irq_req_o = req_vec;

    // R8: one cycle after the enable is seen low, nothing is requested or pending.
    assert_quiet_when_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (req_vec == '0 && pend_vec == '0));

endmodule

// File: tb/pcie_uirq_handshaker_test.sv
`timescale 1ns / 1ps
module pcie_uirq_handshaker_test;

    localparam int N = 16;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] src = '0;
    logic [N-1:0] ack = '0;
    logic [N-1:0] req;
    logic [3:0]   s_awaddr = '0;
    logic         s_awvalid = 1'b0;
    logic         s_awready;
    logic [31:0]  s_wdata = '0;
    logic         s_wvalid = 1'b0;
    logic         s_wready;
    logic [1:0]   s_bresp;
    logic         s_bvalid;
    logic         s_bready = 1'b1;
    logic [3:0]   s_araddr = '0;
    logic         s_arvalid = 1'b0;
    logic         s_arready;
    logic [31:0]  s_rdata;
    logic [1:0]   s_rresp;
    logic         s_rvalid;
    logic         s_rready = 1'b1;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    pcie_uirq_handshaker #(.NUM_LINES(N), .SYNC_STAGES(3), .ADDR_W(4)) uut (
        .clk(clk), .rst_n(rst_n), .src_i(src), .irq_ack_i(ack), .irq_req_o(req),
        .s_awaddr(s_awaddr), .s_awvalid(s_awvalid), .s_awready(s_awready),
        .s_wdata(s_wdata), .s_wvalid(s_wvalid), .s_wready(s_wready),
        .s_bresp(s_bresp), .s_bvalid(s_bvalid), .s_bready(s_bready),
        .s_araddr(s_araddr), .s_arvalid(s_arvalid), .s_arready(s_arready),
        .s_rdata(s_rdata), .s_rresp(s_rresp), .s_rvalid(s_rvalid), .s_rready(s_rready)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    // All tasks start and end just after a falling edge.
    task automatic idle(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic axi_wr(input logic [3:0] a, input logic [31:0] d);
        s_awaddr = a; s_wdata = d; s_awvalid = 1'b1; s_wvalid = 1'b1;
        while (!s_awready) @(negedge clk);
        @(negedge clk);
        s_awvalid = 1'b0; s_wvalid = 1'b0;
        chk("R11 write response", {29'd0, s_bvalid, s_bresp}, 32'h4);
    endtask

    task automatic axi_rd(input logic [3:0] a, output logic [31:0] d);
        s_araddr = a; s_arvalid = 1'b1;
        while (!s_arready) @(negedge clk);
        @(negedge clk);
        s_arvalid = 1'b0;
        d = s_rdata;
        chk("R11 read response", {29'd0, s_rvalid, s_rresp}, 32'h4);
    endtask

    task automatic src_pulse(input int l);
        src[l] = 1'b1; idle(6);
        src[l] = 1'b0; idle(6);
    endtask

    task automatic ack_pulse(input int l);
        ack[l] = 1'b1; idle(1);
        ack[l] = 1'b0; idle(2);
    endtask

    task automatic sw_clear(input int l);
        axi_wr(4'h0, 32'd1 << l);
        idle(3);
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end

    initial begin
        logic [31:0] rd;
        logic [31:0] oh;
        idle(4);
        rst_n = 1'b1;
        idle(1);

        // Reset state
        chk("R8 reset requests", 32'(req), 32'h0);
        chk("R11 reset channel idle", {29'd0, s_awready, s_bvalid, s_rvalid}, 32'h4);
        axi_rd(4'h4, rd); chk("R6 reset control", rd, 32'h0);
        axi_rd(4'h8, rd); chk("R11 reset status", rd, 32'h0);

        // R8: edges ignored while disabled
        src_pulse(5);
        chk("R8 disabled source ignored", 32'(req), 32'h0);
        axi_rd(4'h8, rd); chk("R8 disabled status", rd, 32'h0);

        // R6: start legacy with the documented value
        axi_wr(4'h4, 32'hFFFF_0000);
        axi_rd(4'h4, rd); chk("R6 control readback", rd, 32'h8000_0000);

        // R2: latency through the synchronizer, level does not retrigger
        src[0] = 1'b1;
        idle(3); chk("R2 no request after 3 edges", 32'(req), 32'h0);
        idle(1); chk("R2 request after 4th edge", 32'(req), 32'h1);
        ack_pulse(0); ack_pulse(0);
        idle(8);
        chk("R2 held level no retrigger", 32'(req), 32'h0);
        src[0] = 1'b0; idle(6);

        // Sweep: every mode on every line
        for (int m = 0; m < 3; m++) begin
            axi_wr(4'h4, 32'h0);
            axi_wr(4'h4, (m == 0) ? 32'hFFFF_0000 : (32'h8000_0000 | 32'(m)));
            axi_rd(4'h4, rd); chk("R9 mode loaded while disabled", rd, 32'h8000_0000 | 32'(m));
            for (int l = 0; l < N; l++) begin
                oh = 32'd1 << l;
                src_pulse(l);
                chk("R1 R2 raise", 32'(req), oh);
                if (m == 0) begin
                    ack_pulse(l);  chk("R3 first ack drops", 32'(req), 32'h0);
                    src_pulse(l);  chk("R3 stays low before second ack", 32'(req), 32'h0);
                    axi_rd(4'h8, rd); chk("R10 pending in status", rd, oh << 16);
                    ack_pulse(l);  chk("R10 pending issued after second ack", 32'(req), oh);
                    ack_pulse(l);  chk("R3 drop again", 32'(req), 32'h0);
                    ack_pulse(l);  chk("R3 second ack no request", 32'(req), 32'h0);
                    axi_rd(4'h8, rd); chk("R3 line free", rd, 32'h0);
                end else if (m == 1) begin
                    ack_pulse(l);  chk("R4 ack keeps request", 32'(req), oh);
                    src_pulse(l);
                    axi_rd(4'h8, rd); chk("R11 status request and pending", rd, (oh << 16) | oh);
                    sw_clear(l);   chk("R10 pending issued after clear", 32'(req), oh);
                    sw_clear(l);   chk("R7 clear drops request", 32'(req), 32'h0);
                    src_pulse(l);  idle(4);
                    chk("R7 clear word self-empties", 32'(req), oh);
                    ack_pulse(l);  sw_clear(l);
                    chk("R4 cleared after ack", 32'(req), 32'h0);
                end else begin
                    ack_pulse(l);  chk("R5 ack drops", 32'(req), 32'h0);
                    src_pulse(l);  chk("R5 raise again", 32'(req), oh);
                    src_pulse(l);
                    axi_rd(4'h8, rd); chk("R10 pending while asserted", rd, (oh << 16) | oh);
                    ack_pulse(l);  chk("R10 pending reissued", 32'(req), oh);
                    ack_pulse(l);  chk("R5 final drop", 32'(req), 32'h0);
                end
            end
        end

        // R1: two lines at once in MSI-X, ack one only
        src[3] = 1'b1; src[7] = 1'b1; idle(6);
        src[3] = 1'b0; src[7] = 1'b0; idle(6);
        chk("R1 two lines raised", 32'(req), 32'h88);
        ack_pulse(3);
        chk("R1 other line untouched", 32'(req), 32'h80);
        ack_pulse(7);

        // R9: mode write while enabled is ignored
        axi_wr(4'h4, 32'h8000_0001);
        axi_rd(4'h4, rd); chk("R9 mode unchanged while enabled", rd, 32'h8000_0002);
        src_pulse(4); ack_pulse(4);
        chk("R9 still MSI-X behaviour", 32'(req), 32'h0);

        // R8: disabling drops requests and pending
        axi_wr(4'h4, 32'h0);
        axi_rd(4'h4, rd); chk("R6 stop keeps mode", rd, 32'h2);
        axi_wr(4'h4, 32'h8000_0001);
        axi_rd(4'h4, rd); chk("R9 mode taken while disabled", rd, 32'h8000_0001);
        src_pulse(1); src_pulse(2); ack_pulse(1); src_pulse(2);
        axi_rd(4'h8, rd); chk("R11 status before disable", rd, 32'h0004_0006);
        axi_wr(4'h4, 32'h0); idle(2);
        chk("R8 disable drops requests", 32'(req), 32'h0);
        axi_rd(4'h8, rd); chk("R8 disable drops pending", rd, 32'h0);
        axi_wr(4'h4, 32'h8000_0001); idle(8);
        chk("R8 re-enable starts empty", 32'(req), 32'h0);

        done = 1'b1;
        finish_run();
    end

endmodule